// File: doc/BRIEF.md
# Descriptor Queue Loader

This block is a memory-mapped slave that feeds four descriptor streams. Two streams belong to a write mover and two to a read mover. Each mover has a normal stream and a priority stream. A wide master can deliver a complete descriptor in a single 512-bit write. A narrow host can build the descriptor one 32-bit word at a time. In both cases the bytes collect in a staging register kept for each queue. The finished descriptor leaves as one valid/ready beat at the moment the top word of the window is written.

When a committing write targets a stream that is not ready, the block holds the master with waitrequest. The write completes in the cycle the stream raises ready. A read of any of the four windows never stalls. It returns the stream's ready flag and the fill count of that queue one cycle later. The block keeps that fill count itself: pushes raise it and pop pulses from the consumer lower it.

Top module: `dq_frontend`

## Requirements
- R1: During and right after reset, no stream is valid, waitrequest and readdatavalid are low, and every queue's fill count is 0.
- R2: A write with all 64 byte enables set pushes one beat in the same cycle. The beat carries bits [173:0] of the write data. Write-data bits at 174 and above never reach any stream.
- R3: A write updates the staging register of its queue in the bytes whose byte enable is set; the other bytes keep their staged value. A write with none of byte enables [63:60] (DWORD 15) set pushes nothing. A write with any of them set pushes the staged bytes merged with its own bytes.
- R4: Each queue stages on its own. Partial writes to different queues may be interleaved, and each later commit carries only the bytes written to that queue.
- R5: A stream is valid only while its ready is high. A committing write to a stream whose ready is low keeps waitrequest high and pushes nothing. The write is accepted, pushing once, in the cycle ready rises.
- R6: Address bits [11:9] select the window: 0 is write-normal (stream 0), 1 is write-priority (stream 1), 4 is read-normal (stream 2), 5 is read-priority (stream 3). Other windows ignore writes, and reads of them return all zeros. At most one stream is valid per cycle.
- R7: A read never asserts waitrequest. One cycle later it gives a one-cycle readdatavalid pulse. The read data holds the stream's ready flag in bit 31 and the fill count in bits [7:0], with every other bit 0.
- R8: The fill count rises by one per push and falls by one per pop pulse. A push and a pop in the same cycle leave it unchanged. It stops at 255 and never goes below 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_addr | input | 12 | Byte address of the slave access |
| s_write | input | 1 | Write request |
| s_read | input | 1 | Read request |
| s_wdata | input | 512 | Write data |
| s_be | input | 64 | Byte enables, four for each DWORD |
| s_waitreq | output | 1 | Holds the master while a commit waits for ready |
| s_rdata | output | 512 | Read data |
| s_rvalid | output | 1 | Read data valid, one cycle after the read |
| q_ready | input | 4 | Ready of each descriptor stream |
| q_pop | input | 4 | Consumer pop pulse for each queue's fill count |
| q_valid | output | 4 | Valid of each descriptor stream |
| q_data | output | 696 | Four 174-bit descriptors, stream 0 in the low bits |

## Verification
The main function is driven in three ways.

- A single full-width write tells a same-cycle commit apart from a staged one.
- A series of one-word writes closed by a write of only the top word shows whether the staged bytes survive until the commit, and whether anything is pushed early.
- Alternating partial writes to two queues expose any sharing of staging state.

A commit held against a low ready shows whether exactly one beat comes out when ready rises. A long run of pushes followed by pops at zero checks both ends of the fill count.

// File: rtl/dqf_pkg.sv
package dqf_pkg;
  localparam int NUM_Q  = 4;
  localparam int SEL_W  = 3;

  typedef enum logic [1:0] {
    Q_WR_NORM = 2'd0,
    Q_WR_PRIO = 2'd1,
    Q_RD_NORM = 2'd2,
    Q_RD_PRIO = 2'd3
  } queue_e;

  // Window code of a queue: mover in bit 2, priority in bit 0.
  function automatic logic [SEL_W-1:0] win_code(input queue_e q);
    logic [1:0] qb;
    qb = q;
    return {qb[1], 1'b0, qb[0]};
  endfunction
endpackage

// File: rtl/dqf_stage.sv
module dqf_stage #(
  parameter int DESC_W = 174,
  parameter int NB     = (DESC_W + 7) / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DESC_W-1:0] wdata,
  input  logic [NB-1:0]     be,
  output logic [DESC_W-1:0] merged
);
  logic [DESC_W-1:0] stage_q;

  always_comb begin
    for (int i = 0; i < DESC_W; i++) begin
      merged[i] = be[i/8] ? wdata[i] : stage_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else if (wr_en) begin
      stage_q <= merged;
    end
  end
endmodule

// File: rtl/dqf_level.sv
module dqf_level #(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [LVL_W-1:0] level
);
  localparam logic [LVL_W-1:0] LVL_MAX = '1;

  logic [LVL_W-1:0] level_q;
  logic [LVL_W-1:0] level_d;

  always_comb begin
    level_d = level_q;
    if (push && !pop && level_q != LVL_MAX) begin
      level_d = level_q + 1'b1;
    end else if (pop && !push && level_q != '0) begin
      level_d = level_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
    end else begin
      level_q <= level_d;
    end
  end

  assign level = level_q;

  AST_LEVEL_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && level != LVL_MAX) |=> (level == $past(level) + 1'b1)); // R8
  AST_LEVEL_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && level == '0) |=> (level == '0)); // R8
  AST_LEVEL_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    (push && level == LVL_MAX) |=> (level >= LVL_MAX - 1'b1)); // R8
endmodule

// File: rtl/dq_frontend.sv
module dq_frontend
  import dqf_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 512,
  parameter int DESC_W    = 174,
  parameter int WIN_SHIFT = 9,
  parameter int LVL_W     = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       s_addr,
  input  logic                    s_write,
  input  logic                    s_read,
  input  logic [DATA_W-1:0]       s_wdata,
  input  logic [DATA_W/8-1:0]     s_be,
  output logic                    s_waitreq,
  output logic [DATA_W-1:0]       s_rdata,
  output logic                    s_rvalid,
  input  logic [NUM_Q-1:0]        q_ready,
  input  logic [NUM_Q-1:0]        q_pop,
  output logic [NUM_Q-1:0]        q_valid,
  output logic [NUM_Q*DESC_W-1:0] q_data
);
  localparam int BYTES  = DATA_W / 8;
  localparam int NB     = (DESC_W + 7) / 8;
  localparam int TOP_LO = BYTES - 4;

  logic [SEL_W-1:0]       sel;
  logic [NUM_Q-1:0]       hit;
  logic [NUM_Q-1:0]       wr_hit;
  logic [NUM_Q-1:0]       accept;
  logic [NUM_Q-1:0]       push;
  logic [LVL_W-1:0]       level [NUM_Q];
  logic                   commit;
  logic                   rd_flag_d, rd_flag_q;
  logic [LVL_W-1:0]       rd_lvl_d, rd_lvl_q;
  logic                   rvalid_q;
  logic                   unused_bits;

  assign sel         = s_addr[ADDR_W-1:WIN_SHIFT];
  assign commit      = |s_be[BYTES-1:TOP_LO];
  assign unused_bits = ^{s_wdata[DATA_W-1:DESC_W], s_be[TOP_LO-1:NB], s_addr[WIN_SHIFT-1:0]};

  always_comb begin
    for (int q = 0; q < NUM_Q; q++) begin
      hit[q] = (sel == win_code(queue_e'(q)));
    end
  end

  assign wr_hit    = hit & {NUM_Q{s_write}};
  assign s_waitreq = commit && |(wr_hit & ~q_ready);
  assign accept    = wr_hit & {NUM_Q{~s_waitreq}};
  assign push      = accept & {NUM_Q{commit}};
  assign q_valid   = push;

  for (genvar g = 0; g < NUM_Q; g++) begin : g_queue
    dqf_stage #(.DESC_W(DESC_W), .NB(NB)) u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (accept[g]),
      .wdata  (s_wdata[DESC_W-1:0]),
      .be     (s_be[NB-1:0]),
      .merged (q_data[g*DESC_W +: DESC_W])
    );
    dqf_level #(.LVL_W(LVL_W)) u_level (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push[g]),
      .pop   (q_pop[g]),
      .level (level[g])
    );
  end

  // Read path: only the flag and the count are stored.
  always_comb begin
    rd_flag_d = 1'b0;
    rd_lvl_d  = '0;
    for (int q = 0; q < NUM_Q; q++) begin
      if (hit[q]) begin
        rd_flag_d = q_ready[q];
        rd_lvl_d  = level[q];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_flag_q <= 1'b0;
      rd_lvl_q  <= '0;
      rvalid_q  <= 1'b0;
    end else begin
      rvalid_q <= s_read;
      if (s_read) begin
        rd_flag_q <= rd_flag_d;
        rd_lvl_q  <= rd_lvl_d;
      end
    end
  end

  always_comb begin
    s_rdata           = '0;
    s_rdata[31]       = rd_flag_q;
    s_rdata[LVL_W-1:0] = rd_lvl_q;
  end
  assign s_rvalid = rvalid_q;

  AST_PUSH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    |(q_valid & ~q_ready) == 1'b0); // R5
  AST_WAIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    s_waitreq |-> (q_valid == '0)); // R5
  AST_ONE_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(q_valid)); // R6
  AST_READ_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    s_waitreq |-> s_write); // R7
  AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    s_read |=> s_rvalid); // R7
  AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !s_read |=> !s_rvalid); // R7
endmodule

// File: tb/tb_dq_frontend.sv
`timescale 1ns/1ps
module tb_dq_frontend;
  localparam int DW = 512;
  localparam int DS = 174;
  localparam int NQ = 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [11:0]     s_addr;
  logic            s_write, s_read;
  logic [DW-1:0]   s_wdata;
  logic [DW/8-1:0] s_be;
  logic            s_waitreq;
  logic [DW-1:0]   s_rdata;
  logic            s_rvalid;
  logic [NQ-1:0]   q_ready, q_pop, q_valid;
  logic [NQ*DS-1:0] q_data;

  int checks = 0;
  int errors = 0;
  int exp_idx[$];
  logic [DS-1:0] exp_dat[$];
  int exp_lvl[NQ];

  always #10 clk = ~clk;

  dq_frontend dut (
    .clk(clk), .rst_n(rst_n), .s_addr(s_addr), .s_write(s_write), .s_read(s_read),
    .s_wdata(s_wdata), .s_be(s_be), .s_waitreq(s_waitreq), .s_rdata(s_rdata),
    .s_rvalid(s_rvalid), .q_ready(q_ready), .q_pop(q_pop), .q_valid(q_valid),
    .q_data(q_data)
  );

  function automatic logic [11:0] win_addr(input int q);
    case (q)
      0: return 12'h000;
      1: return 12'h200;
      2: return 12'h800;
      3: return 12'hA00;
      default: return 12'h400;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: compares every pushed beat with the scoreboard.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int q = 0; q < NQ; q++) begin
        if (q_valid[q]) begin
          checks++;
          if (exp_idx.size() == 0) begin
            errors++;
            $display("FAIL R3 unexpected push actual=%0h expected=none", q);
          end else begin
            int ei;
            logic [DS-1:0] ed;
            ei = exp_idx.pop_front();
            ed = exp_dat.pop_front();
            if (ei != q || q_data[q*DS +: DS] != ed) begin
              errors++;
              $display("FAIL R2 push stream actual=%0d/%0h expected=%0d/%0h",
                       q, q_data[q*DS +: DS], ei, ed);
            end
          end
        end
      end
    end
  end

  task automatic expect_push(input int q, input logic [DS-1:0] d);
    exp_idx.push_back(q);
    exp_dat.push_back(d);
    if (exp_lvl[q] < 255) exp_lvl[q]++;
  endtask

  task automatic wr(input logic [11:0] a, input logic [DW-1:0] d, input logic [DW/8-1:0] be);
    @(posedge clk); #1;
    s_addr = a; s_wdata = d; s_be = be; s_write = 1'b1;
    @(negedge clk);
    while (s_waitreq) @(negedge clk);
    @(posedge clk); #1;
    s_write = 1'b0; s_be = '0;
  endtask

  task automatic wr_dword(input int q, input int k, input logic [31:0] v);
    logic [DW-1:0] d;
    logic [DW/8-1:0] be;
    d = '0; be = '0;
    d[k*32 +: 32] = v;
    be[k*4 +: 4] = 4'hF;
    wr(win_addr(q), d, be);
  endtask

  task automatic rd_check(input logic [11:0] a, input logic [DW-1:0] exp, input string req);
    @(posedge clk); #1;
    s_addr = a; s_read = 1'b1;
    @(negedge clk);
    check(s_waitreq == 1'b0, "R7 no wait on read", DW'(s_waitreq), '0);
    @(posedge clk); #1;
    s_read = 1'b0;
    @(negedge clk);
    check(s_rvalid == 1'b1, "R7 rvalid", DW'(s_rvalid), DW'(1));
    check(s_rdata == exp, req, s_rdata, exp);
    @(negedge clk);
    check(s_rvalid == 1'b0, "R7 rvalid pulse", DW'(s_rvalid), '0);
  endtask

  function automatic logic [DW-1:0] stat(input bit rdy, input int lvl);
    logic [DW-1:0] r;
    r = '0; r[31] = rdy; r[7:0] = lvl[7:0];
    return r;
  endfunction

  task automatic pop(input int q);
    @(posedge clk); #1; q_pop[q] = 1'b1;
    @(posedge clk); #1; q_pop[q] = 1'b0;
    if (exp_lvl[q] > 0) exp_lvl[q]--;
  endtask

  task automatic finish_run;
    checks++;
    if (exp_idx.size() != 0) begin
      errors++;
      $display("FAIL R5 missing pushes actual=0 expected=%0d", exp_idx.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    logic [DS-1:0] e;
    rst_n = 1'b0; s_addr = '0; s_write = 0; s_read = 0; s_wdata = '0; s_be = '0;
    q_ready = '1; q_pop = '0;
    for (int q = 0; q < NQ; q++) exp_lvl[q] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 during reset
    check(q_valid == '0 && s_waitreq == 0 && s_rvalid == 0, "R1 reset outputs",
          DW'({q_valid, s_waitreq, s_rvalid}), '0);
    @(posedge clk); #1; rst_n = 1'b1;
    for (int q = 0; q < NQ; q++) rd_check(win_addr(q), stat(1, 0), "R1 level zero");

    // R2: full-width commit, upper bits set
    d = {16{32'hA5C3_0F1E}} ^ {DW{1'b1}} << 100;
    expect_push(0, d[DS-1:0]);
    wr(win_addr(0), d, '1);
    rd_check(win_addr(0), stat(1, exp_lvl[0]), "R7 R8 level after push");

    // R3: one dword at a time then top dword only
    e = '0;
    for (int k = 0; k < 6; k++) begin
      logic [191:0] w;
      w = '0; w[k*32 +: 32] = 32'h1357_0000 + k;
      e = e | w[DS-1:0];
      wr_dword(2, k, 32'h1357_0000 + k);
    end
    expect_push(2, e);
    wr_dword(2, 15, 32'hFFFF_FFFF);
    rd_check(win_addr(2), stat(1, 1), "R3 single commit level");

    // R4: interleaved staging on streams 1 and 3
    begin
      logic [DS-1:0] e1, e3;
      e1 = '0; e3 = '0;
      for (int k = 0; k < 6; k++) begin
        logic [191:0] w1, w3;
        w1 = '0; w3 = '0;
        w1[k*32 +: 32] = 32'hB100_0000 + k;
        w3[k*32 +: 32] = 32'h3D00_0000 + k;
        e1 = e1 | w1[DS-1:0];
        e3 = e3 | w3[DS-1:0];
        wr_dword(1, k, 32'hB100_0000 + k);
        wr_dword(3, k, 32'h3D00_0000 + k);
      end
      expect_push(3, e3);
      wr_dword(3, 15, 32'h0);
      expect_push(1, e1);
      wr_dword(1, 15, 32'h0);
    end

    // R5: commit stalls while ready is low
    q_ready[1] = 1'b0;
    rd_check(win_addr(1), stat(0, exp_lvl[1]), "R7 ready flag low");
    d = {16{32'h600D_CAFE}};
    @(posedge clk); #1;
    s_addr = win_addr(1); s_wdata = d; s_be = '1; s_write = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check(s_waitreq == 1'b1 && q_valid == '0, "R5 stall", DW'({s_waitreq, q_valid}), DW'(5'b10000));
    end
    expect_push(1, d[DS-1:0]);
    @(posedge clk); #1; q_ready[1] = 1'b1;
    @(negedge clk);
    check(s_waitreq == 1'b0, "R5 release", DW'(s_waitreq), '0);
    @(posedge clk); #1; s_write = 1'b0; s_be = '0;
    rd_check(win_addr(1), stat(1, exp_lvl[1]), "R5 single push level");

    // R6: unmapped window
    wr(12'h400, {16{32'hDEAD_BEEF}}, '1);
    wr(12'hE00, {16{32'hDEAD_BEEF}}, '1);
    rd_check(12'h400, '0, "R6 unmapped read zero");
    rd_check(12'h600, '0, "R6 unmapped read zero");

    // R8: pop and floor
    pop(0);
    rd_check(win_addr(0), stat(1, 0), "R8 pop to zero");
    pop(0);
    rd_check(win_addr(0), stat(1, 0), "R8 floor");

    // R8: saturation on stream 3
    for (int i = 0; i < 260; i++) begin
      d = '0; d[31:0] = i; d[DS-1:DS-8] = 8'h5A;
      expect_push(3, d[DS-1:0]);
      wr(win_addr(3), d, '1);
    end
    rd_check(win_addr(3), stat(1, 255), "R8 saturate");
    pop(3);
    rd_check(win_addr(3), stat(1, 254), "R8 pop after saturate");

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule